// File: doc/BRIEF.md
# Debug Park-Loop Handshake Slave

This block is a memory-mapped slave on the CPU's data bus. It sits between a debugger and a CPU core that is parked in debug mode. It claims one 256-byte window and splits it into four 64-byte regions:

- a small code ROM that holds the park-loop entry words;
- a program buffer;
- an abstract data buffer;
- a handshake word.

The debugger raises requests with one-cycle pulses. The parked CPU polls those requests with byte loads. It reports its progress with byte stores to the handshake word. Each store is recognised by the byte lane it enables, and the data written is ignored.

The handshake is driven by a four-state machine:

- RUNNING is the reset state. The CPU is executing normally.
- PARKED: the CPU has acknowledged a halt and is waiting in the park loop.
- EXECUTING: the CPU has acknowledged an execute request and runs the program buffer.
- TRAPPED: the program buffer raised an exception, and the CPU has not yet re-entered the park loop.

The transitions are:

- halt-ack leads from any state to PARKED.
- resume-ack leads from PARKED to RUNNING.
- exec-ack leads from PARKED to EXECUTING.
- exception-ack leads from EXECUTING to TRAPPED.

The debugger sees the state as level flags, together with a sticky exception flag. Both buffers can be read and written from the CPU bus and from a word-wide debugger port.

Top module: `dbg_park_port`

## Requirements
- R1: The window starts at WIN_BASE (default 0xFFFFFF00) and spans 256 bytes. Offsets 0x00-0x3F are the ROM, 0x40-0x7F the program buffer, 0x80-0xBF the data buffer and 0xC0-0xFF the handshake region. A request whose word address lies outside the window is never acknowledged.
- R2: For a claimed request, bus_ack is high for exactly the one cycle after the request cycle. During that cycle bus_rdata carries the addressed word for a read and zero for a write. bus_rdata is zero whenever no claimed read is being answered.
- R3: A ROM read returns EXC_ENTRY_WORD at offset 0x00, HALT_ENTRY_WORD at offset 0x08 and FILL_WORD at every other offset. Writes to the ROM change nothing.
- R4: Both buffers hold 16 words each and reset to zero. A CPU write updates only the enabled lanes, where lane k is bits 8k+7..8k. A debugger write replaces a whole word; dbg_buf_sel 0 selects the program buffer and 1 the data buffer. dbg_buf_rdata shows the selected word combinationally.
- R5: When the debugger port and the CPU write the same buffer word in the same cycle, the word takes the debugger value.
- R6: A read of handshake offset 0xC0 returns bit 8 = resume pending and bit 16 = execute pending, with all other bits zero. Reads of the other handshake words return zero.
- R7: A dbg_resume_pulse sets resume pending. A write to 0xC0 with lane 1 enabled clears it. If both happen in the same cycle, the flag is set.
- R8: A dbg_exec_pulse sets execute pending. A write to 0xC0 with lane 2 enabled clears it. If both happen in the same cycle, the flag is set.
- R9: An acknowledge takes effect purely from its lane enable on a write to 0xC0. The value of bus_wdata has no influence.
- R10: The handshake state resets to RUNNING and follows these rules:
  - lane 0 (halt-ack) moves it from any state to PARKED, and this takes priority over the other acknowledges;
  - in PARKED, lane 1 (resume-ack) moves it to RUNNING, and otherwise lane 2 (exec-ack) moves it to EXECUTING;
  - in EXECUTING, lane 3 (exception-ack) moves it to TRAPPED;
  - any other acknowledge leaves the state unchanged.
- R11: st_running is high in RUNNING, st_halted in PARKED and st_executing in EXECUTING. In TRAPPED none of them is high. All of them change in the cycle after the acknowledge.
- R12: st_exception resets to 0. An exception-ack sets it and an exec-ack clears it; if both come in the same cycle, it is set.
- R13: After reset, bus_ack = 0, bus_rdata = 0, both request flags are 0, st_running = 1 and the other status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | CPU bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 30 | Word address (byte address bits 31..2) |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after a claimed request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| dbg_resume_pulse | input | 1 | Debugger resume request pulse |
| dbg_exec_pulse | input | 1 | Debugger execute request pulse |
| dbg_buf_we | input | 1 | Debugger buffer word write |
| dbg_buf_sel | input | 1 | 0 = program buffer, 1 = data buffer |
| dbg_buf_idx | input | 4 | Debugger buffer word index |
| dbg_buf_wdata | input | 32 | Debugger write word |
| dbg_buf_rdata | output | 32 | Selected buffer word (combinational) |
| st_halted | output | 1 | CPU parked (PARKED) |
| st_running | output | 1 | CPU running (RUNNING) |
| st_executing | output | 1 | CPU running the program buffer (EXECUTING) |
| st_exception | output | 1 | Sticky exception flag |

## Verification
The handshake word is exercised in three ways:

- every single-lane acknowledge in each state, which tells the four transitions apart from ignored acknowledges;
- multi-lane writes, which expose the halt-over-resume-over-execute priority;
- acknowledges carrying all-ones data, which confirm that the data is ignored.

Request pulses are placed on the same cycle as their clearing acknowledges, which separates set-wins behaviour from clear-wins behaviour. Buffer traffic mixes partial lane enables and debugger writes aimed at the same word index as a CPU write, which exposes lane masking and the collision priority. Addresses just outside the window confirm that it is decoded on the full upper address.

// File: rtl/dbg_park_pkg.sv
package dbg_park_pkg;

    typedef enum logic [1:0] {
        RG_ROM  = 2'd0,
        RG_PBUF = 2'd1,
        RG_DATA = 2'd2,
        RG_STAT = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        HS_RUNNING   = 2'd0,
        HS_PARKED    = 2'd1,
        HS_EXECUTING = 2'd2,
        HS_TRAPPED   = 2'd3
    } hs_state_e;

    localparam int unsigned WIN_BYTES    = 256;
    localparam int unsigned REGION_BYTES = 64;

    // byte lanes of the handshake word
    localparam int unsigned LANE_HALT   = 0;
    localparam int unsigned LANE_RESUME = 1;
    localparam int unsigned LANE_EXEC   = 2;
    localparam int unsigned LANE_EXC    = 3;

endpackage

// File: rtl/dbg_park_decode.sv
module dbg_park_decode
    import dbg_park_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_FF00,
    localparam int unsigned BYTE_W  = $clog2(DATA_W / 8),
    localparam int unsigned OFS_W   = $clog2(WIN_BYTES),
    localparam int unsigned IDX_W   = $clog2(REGION_BYTES / (DATA_W / 8))
) (
    input  logic [ADDR_W-1:BYTE_W] waddr,
    output logic                   hit,
    output region_e                region,
    output logic [IDX_W-1:0]       word_idx
);

    always_comb begin
        hit      = (waddr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
        region   = region_e'(waddr[OFS_W-1:OFS_W-2]);
        word_idx = waddr[OFS_W-3:BYTE_W];
    end

endmodule

// File: rtl/dbg_park_buf.sv
module dbg_park_buf #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 16,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [LANES-1:0]  cpu_be,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dbg_we,
    input  logic [IDX_W-1:0]  dbg_idx,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (dbg_we && dbg_idx == IDX_W'(w)) begin
                mem[w] <= dbg_wdata;                 // debugger side wins
            end else if (cpu_we && cpu_idx == IDX_W'(w)) begin
                for (int b = 0; b < LANES; b++) begin
                    if (cpu_be[b]) mem[w][8*b +: 8] <= cpu_wdata[8*b +: 8];
                end
            end
        end
    end

    assign cpu_rdata = mem[cpu_idx];
    assign dbg_rdata = mem[dbg_idx];

    AST_DBG_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && dbg_we && cpu_idx == dbg_idx) |=> (mem[$past(dbg_idx)] == $past(dbg_wdata))); // R5

endmodule

// File: rtl/dbg_park_hs.sv
module dbg_park_hs
    import dbg_park_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_halt,
    input  logic ack_resume,
    input  logic ack_exec,
    input  logic ack_exc,
    input  logic req_resume_in,
    input  logic req_exec_in,
    output logic resume_pend,
    output logic exec_pend,
    output logic st_halted,
    output logic st_running,
    output logic st_executing,
    output logic st_exception
);

    hs_state_e state, state_nx;
    logic      exc_flag;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (ack_halt) begin
            state_nx = HS_PARKED;
        end else begin
            unique case (state)
                HS_RUNNING:   state_nx = HS_RUNNING;
                HS_PARKED: begin
                    if (ack_resume)    state_nx = HS_RUNNING;
                    else if (ack_exec) state_nx = HS_EXECUTING;
                end
                HS_EXECUTING: if (ack_exc) state_nx = HS_TRAPPED;
                HS_TRAPPED:   state_nx = HS_TRAPPED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_RUNNING;
        else        state <= state_nx;
    end

    // request and exception flags: a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_pend <= 1'b0;
            exec_pend   <= 1'b0;
            exc_flag    <= 1'b0;
        end else begin
            if (req_resume_in)   resume_pend <= 1'b1;
            else if (ack_resume) resume_pend <= 1'b0;
            if (req_exec_in)     exec_pend   <= 1'b1;
            else if (ack_exec)   exec_pend   <= 1'b0;
            if (ack_exc)         exc_flag    <= 1'b1;
            else if (ack_exec)   exc_flag    <= 1'b0;
        end
    end

    // state outputs
    always_comb begin
        st_halted    = 1'b0;
        st_running   = 1'b0;
        st_executing = 1'b0;
        unique case (state)
            HS_RUNNING:   st_running   = 1'b1;
            HS_PARKED:    st_halted    = 1'b1;
            HS_EXECUTING: st_executing = 1'b1;
            HS_TRAPPED:   ;
        endcase
        st_exception = exc_flag;
    end

    AST_RESUME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume_in |=> resume_pend); // R7
    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_resume && !req_resume_in) |=> !resume_pend); // R7
    AST_EXEC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        req_exec_in |=> exec_pend); // R8
    AST_EXEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_exec && !req_exec_in) |=> !exec_pend); // R8
    AST_HALT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_halt |=> (st_halted && !st_running && !st_executing)); // R10
    AST_PARK_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_PARKED && ack_exec && !ack_resume && !ack_halt) |=> st_executing); // R10
    AST_EXC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_exc |=> st_exception); // R12

endmodule

// File: rtl/dbg_park_port.sv
module dbg_park_port
    import dbg_park_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE        = 32'hFFFF_FF00,
    parameter logic [DATA_W-1:0] EXC_ENTRY_WORD  = 32'hA5A5_0001,
    parameter logic [DATA_W-1:0] HALT_ENTRY_WORD = 32'hA5A5_0002,
    parameter logic [DATA_W-1:0] FILL_WORD       = 32'hA5A5_00FF,
    localparam int unsigned LANES     = DATA_W / 8,
    localparam int unsigned BYTE_W    = $clog2(LANES),
    localparam int unsigned BUF_WORDS = REGION_BYTES / LANES,
    localparam int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:BYTE_W] bus_waddr,
    input  logic [LANES-1:0]       bus_be,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic                   bus_ack,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   dbg_resume_pulse,
    input  logic                   dbg_exec_pulse,
    input  logic                   dbg_buf_we,
    input  logic                   dbg_buf_sel,
    input  logic [IDX_W-1:0]       dbg_buf_idx,
    input  logic [DATA_W-1:0]      dbg_buf_wdata,
    output logic [DATA_W-1:0]      dbg_buf_rdata,
    output logic                   st_halted,
    output logic                   st_running,
    output logic                   st_executing,
    output logic                   st_exception
);

    localparam int unsigned ROM_EXC_IDX  = 0;
    localparam int unsigned ROM_HALT_IDX = 8 / LANES;
    localparam int unsigned NBUF         = 2;

    logic              hit;
    region_e           region;
    logic [IDX_W-1:0]  word_idx;
    logic              claim, stat_wr;
    logic              ack_halt, ack_resume, ack_exec, ack_exc;
    logic              resume_pend, exec_pend;
    logic [DATA_W-1:0] rd_word, stat_word, rom_word;
    logic [DATA_W-1:0] buf_cpu_rd [NBUF];
    logic [DATA_W-1:0] buf_dbg_rd [NBUF];

    dbg_park_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WIN_BASE (WIN_BASE)
    ) u_dec (
        .waddr    (bus_waddr),
        .hit      (hit),
        .region   (region),
        .word_idx (word_idx)
    );

    assign claim   = bus_req && hit;
    assign stat_wr = claim && bus_we && region == RG_STAT && word_idx == '0;

    always_comb begin
        ack_halt   = stat_wr && bus_be[LANE_HALT];
        ack_resume = stat_wr && bus_be[LANE_RESUME];
        ack_exec   = stat_wr && bus_be[LANE_EXEC];
        ack_exc    = stat_wr && bus_be[LANE_EXC];
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        localparam region_e RG_THIS = (g == 0) ? RG_PBUF : RG_DATA;
        dbg_park_buf #(
            .DATA_W (DATA_W),
            .WORDS  (BUF_WORDS)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .cpu_we    (claim && bus_we && region == RG_THIS),
            .cpu_be    (bus_be),
            .cpu_idx   (word_idx),
            .cpu_wdata (bus_wdata),
            .cpu_rdata (buf_cpu_rd[g]),
            .dbg_we    (dbg_buf_we && dbg_buf_sel == 1'(g)),
            .dbg_idx   (dbg_buf_idx),
            .dbg_wdata (dbg_buf_wdata),
            .dbg_rdata (buf_dbg_rd[g])
        );
    end

    assign dbg_buf_rdata = buf_dbg_rd[dbg_buf_sel];

    dbg_park_hs u_hs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ack_halt      (ack_halt),
        .ack_resume    (ack_resume),
        .ack_exec      (ack_exec),
        .ack_exc       (ack_exc),
        .req_resume_in (dbg_resume_pulse),
        .req_exec_in   (dbg_exec_pulse),
        .resume_pend   (resume_pend),
        .exec_pend     (exec_pend),
        .st_halted     (st_halted),
        .st_running    (st_running),
        .st_executing  (st_executing),
        .st_exception  (st_exception)
    );

    // read word selection
    always_comb begin
        if (word_idx == IDX_W'(ROM_EXC_IDX))       rom_word = EXC_ENTRY_WORD;
        else if (word_idx == IDX_W'(ROM_HALT_IDX)) rom_word = HALT_ENTRY_WORD;
        else                                       rom_word = FILL_WORD;

        stat_word = '0;
        if (word_idx == '0) begin
            stat_word[8*LANE_RESUME] = resume_pend;
            stat_word[8*LANE_EXEC]   = exec_pend;
        end

        unique case (region)
            RG_ROM:  rd_word = rom_word;
            RG_PBUF: rd_word = buf_cpu_rd[0];
            RG_DATA: rd_word = buf_cpu_rd[1];
            RG_STAT: rd_word = stat_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= claim;
            bus_rdata <= (claim && !bus_we) ? rd_word : '0;
        end
    end

    AST_ACK_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> bus_ack); // R2
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && hit) |=> !bus_ack); // R1
    AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> (bus_rdata == '0)); // R2
    AST_ROM_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !bus_we && region == RG_ROM && word_idx == IDX_W'(ROM_HALT_IDX))
        |=> (bus_rdata == HALT_ENTRY_WORD)); // R3

endmodule

// File: tb/sim_dbg_park_port.sv
`timescale 1ns/1ps
module sim_dbg_park_port;

    localparam logic [31:0] EXC_W  = 32'hA5A5_0001;
    localparam logic [31:0] HALT_W = 32'hA5A5_0002;
    localparam logic [31:0] FILL_W = 32'hA5A5_00FF;
    localparam int S_RUN = 0, S_PARK = 1, S_EXEC = 2, S_TRAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] b_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        dbg_resume_pulse = 1'b0, dbg_exec_pulse = 1'b0;
    logic        dbg_buf_we = 1'b0, dbg_buf_sel = 1'b0;
    logic [3:0]  dbg_buf_idx = '0;
    logic [31:0] dbg_buf_wdata = '0;
    logic [31:0] dbg_buf_rdata;
    logic        st_halted, st_running, st_executing, st_exception;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_pbuf [16];
    logic [31:0] m_dbuf [16];
    logic        m_rp = 0, m_ep = 0, m_exc = 0;
    int          m_st = S_RUN;

    always #10 clk = ~clk;

    dbg_park_port u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_waddr(b_addr[31:2]),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .dbg_resume_pulse(dbg_resume_pulse), .dbg_exec_pulse(dbg_exec_pulse),
        .dbg_buf_we(dbg_buf_we), .dbg_buf_sel(dbg_buf_sel),
        .dbg_buf_idx(dbg_buf_idx), .dbg_buf_wdata(dbg_buf_wdata),
        .dbg_buf_rdata(dbg_buf_rdata),
        .st_halted(st_halted), .st_running(st_running),
        .st_executing(st_executing), .st_exception(st_exception)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        logic [3:0] i;
        i = a[5:2];
        case (a[7:6])
            2'd0:    return (i == 0) ? EXC_W : (i == 2) ? HALT_W : FILL_W;
            2'd1:    return m_pbuf[i];
            2'd2:    return m_dbuf[i];
            default: return (i == 0) ? {15'd0, m_ep, 7'd0, m_rp, 8'd0} : 32'd0;
        endcase
    endfunction

    function automatic int next_st(input int st, input logic ah, ar, ae, ax);
        if (ah) return S_PARK;
        case (st)
            S_PARK:  return ar ? S_RUN : (ae ? S_EXEC : S_PARK);
            S_EXEC:  return ax ? S_TRAP : S_EXEC;
            default: return st;
        endcase
    endfunction

    task automatic idle();
        bus_req = 0; bus_we = 0; bus_be = '0; bus_wdata = '0;
        dbg_resume_pulse = 0; dbg_exec_pulse = 0; dbg_buf_we = 0;
    endtask

    // one clock with the currently driven inputs; called at a negedge
    task automatic tick(input string tag);
        logic        claimed, ah, ar, ae, ax;
        logic [31:0] e_rd, dref;
        logic        e_ack;
        #1;
        dref = dbg_buf_sel ? m_dbuf[dbg_buf_idx] : m_pbuf[dbg_buf_idx];
        chk({tag, " R4 dbg_buf_rdata"}, dbg_buf_rdata, dref);
        claimed = bus_req && (b_addr[31:8] == 24'hFFFFFF);
        e_ack = claimed;
        e_rd  = (claimed && !bus_we) ? exp_read(b_addr) : 32'd0;
        ah = 0; ar = 0; ae = 0; ax = 0;
        if (claimed && bus_we) begin
            case (b_addr[7:6])
                2'd1: for (int b = 0; b < 4; b++)
                          if (bus_be[b]) m_pbuf[b_addr[5:2]][8*b +: 8] = bus_wdata[8*b +: 8];
                2'd2: for (int b = 0; b < 4; b++)
                          if (bus_be[b]) m_dbuf[b_addr[5:2]][8*b +: 8] = bus_wdata[8*b +: 8];
                2'd3: if (b_addr[5:2] == 0) begin
                          ah = bus_be[0]; ar = bus_be[1]; ae = bus_be[2]; ax = bus_be[3];
                      end
                default: ;
            endcase
        end
        if (dbg_buf_we) begin
            if (dbg_buf_sel) m_dbuf[dbg_buf_idx] = dbg_buf_wdata;
            else             m_pbuf[dbg_buf_idx] = dbg_buf_wdata;
        end
        m_st  = next_st(m_st, ah, ar, ae, ax);
        m_rp  = dbg_resume_pulse ? 1'b1 : (ar ? 1'b0 : m_rp);
        m_ep  = dbg_exec_pulse   ? 1'b1 : (ae ? 1'b0 : m_ep);
        m_exc = ax ? 1'b1 : (ae ? 1'b0 : m_exc);
        @(posedge clk);
        @(negedge clk);
        idle();
        chk({tag, " R2 bus_ack"}, {31'd0, bus_ack}, {31'd0, e_ack});
        chk({tag, " R2 bus_rdata"}, bus_rdata, e_rd);
        chk({tag, " R11 status"}, {28'd0, st_running, st_halted, st_executing, st_exception},
            {28'd0, m_st == S_RUN, m_st == S_PARK, m_st == S_EXEC, m_exc});
    endtask

    task automatic cpu_wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d,
                          input string tag);
        bus_req = 1; bus_we = 1; b_addr = a; bus_be = be; bus_wdata = d;
        tick(tag);
    endtask

    task automatic cpu_rd(input logic [31:0] a, input string tag);
        bus_req = 1; bus_we = 0; b_addr = a; bus_be = 4'hF;
        tick(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_pbuf[i] = '0; m_dbuf[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk("R13 ack", {31'd0, bus_ack}, 32'd0);
        chk("R13 rdata", bus_rdata, 32'd0);
        chk("R13 status", {28'd0, st_running, st_halted, st_executing, st_exception}, 32'h8);
        cpu_rd(32'hFFFF_FFC0, "R13 flags");

        // R3 ROM entries and write protection
        cpu_rd(32'hFFFF_FF00, "R3 exc entry");
        cpu_rd(32'hFFFF_FF08, "R3 halt entry");
        cpu_rd(32'hFFFF_FF04, "R3 fill");
        cpu_rd(32'hFFFF_FF3C, "R3 fill end");
        cpu_wr(32'hFFFF_FF08, 4'hF, 32'h1234_5678, "R3 rom write");
        cpu_rd(32'hFFFF_FF08, "R3 after write");

        // R1 unclaimed
        cpu_rd(32'hFFFF_FE00, "R1 below window");
        cpu_wr(32'h0000_0040, 4'hF, 32'hDEAD_BEEF, "R1 low address");
        cpu_rd(32'hFFFF_FF40, "R1 pbuf untouched");

        // R4 buffers with lane enables
        cpu_wr(32'hFFFF_FF44, 4'hF, 32'h1122_3344, "R4 pbuf full");
        cpu_wr(32'hFFFF_FF44, 4'b0101, 32'hAABB_CCDD, "R4 pbuf lanes");
        cpu_rd(32'hFFFF_FF44, "R4 pbuf read");
        cpu_wr(32'hFFFF_FFBC, 4'b1000, 32'h7700_0000, "R4 dbuf lane3");
        cpu_rd(32'hFFFF_FFBC, "R4 dbuf read");
        dbg_buf_we = 1; dbg_buf_sel = 1; dbg_buf_idx = 4'd5; dbg_buf_wdata = 32'hCAFE_F00D;
        tick("R4 dbg write");
        cpu_rd(32'hFFFF_FF94, "R4 cpu sees dbg word");

        // R5 collision
        bus_req = 1; bus_we = 1; b_addr = 32'hFFFF_FF4C; bus_be = 4'hF; bus_wdata = 32'h1111_1111;
        dbg_buf_we = 1; dbg_buf_sel = 0; dbg_buf_idx = 4'd3; dbg_buf_wdata = 32'h2222_2222;
        tick("R5 collision");
        cpu_rd(32'hFFFF_FF4C, "R5 debugger won");

        // R9 R10 halt ack with nonzero data
        cpu_wr(32'hFFFF_FFC0, 4'b0001, 32'hFFFF_FFFF, "R9 R10 halt ack");
        dbg_resume_pulse = 1; tick("R7 resume pulse");
        cpu_rd(32'hFFFF_FFC0, "R6 resume pending");
        dbg_exec_pulse = 1; tick("R8 exec pulse");
        cpu_rd(32'hFFFF_FFC0, "R6 both pending");
        cpu_rd(32'hFFFF_FFC4, "R6 other word");
        cpu_wr(32'hFFFF_FFC0, 4'b0100, 32'h00FF_0000, "R8 R10 exec ack");
        cpu_rd(32'hFFFF_FFC0, "R8 exec cleared");
        cpu_wr(32'hFFFF_FFC0, 4'b0010, 32'h0, "R10 resume ack ignored in EXECUTING");
        cpu_wr(32'hFFFF_FFC0, 4'b1000, 32'h0, "R10 R12 exception ack");
        cpu_wr(32'hFFFF_FFC0, 4'b0001, 32'h0, "R10 trapped to parked");
        cpu_wr(32'hFFFF_FFC0, 4'b0011, 32'h0, "R10 halt beats resume");
        cpu_wr(32'hFFFF_FFC0, 4'b0110, 32'h0, "R10 resume beats exec");
        cpu_wr(32'hFFFF_FFC0, 4'b0100, 32'h0, "R10 exec ack ignored in RUNNING");
        cpu_wr(32'hFFFF_FFC4, 4'b0001, 32'h0, "R10 other word no ack");
        dbg_resume_pulse = 1; bus_req = 1; bus_we = 1; b_addr = 32'hFFFF_FFC0; bus_be = 4'b0010;
        tick("R7 set wins");
        cpu_rd(32'hFFFF_FFC0, "R7 still pending");
        cpu_wr(32'hFFFF_FFC0, 4'b0001, 32'h0, "R10 park again");
        dbg_exec_pulse = 1; bus_req = 1; bus_we = 1; b_addr = 32'hFFFF_FFC0; bus_be = 4'b0100;
        tick("R8 R12 set wins, exception cleared");
        cpu_rd(32'hFFFF_FFC0, "R8 still pending");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] rg;
            logic [3:0] ix;
            rg = 2'($urandom_range(0, 3));
            ix = 4'($urandom_range(0, 15));
            if (rg == 2'd3 && $urandom_range(0, 3) != 0) ix = 4'd0;
            b_addr    = {24'hFFFFFF, rg, ix, 2'b00};
            if ($urandom_range(0, 9) == 0) b_addr[31:28] = 4'h1;
            bus_req   = ($urandom_range(0, 3) != 0);
            bus_we    = 1'($urandom_range(0, 1));
            bus_be    = 4'($urandom_range(0, 15));
            bus_wdata = $urandom;
            dbg_resume_pulse = ($urandom_range(0, 7) == 0);
            dbg_exec_pulse   = ($urandom_range(0, 7) == 0);
            dbg_buf_we    = ($urandom_range(0, 3) == 0);
            dbg_buf_sel   = 1'($urandom_range(0, 1));
            dbg_buf_idx   = ($urandom_range(0, 1) == 0) ? ix : 4'($urandom_range(0, 15));
            dbg_buf_wdata = $urandom;
            tick("R4 R10 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule